// File: doc/BRIEF.md
# Transmit Buffer Abort Controller

This block tracks the code field of a bank of CAN transmit message buffers and handles requests from software to withdraw a queued frame. Software writes a 4-bit code into a buffer. With the abort feature enabled, the code 1001 asks the block to cancel that buffer's transmission. The transmitter reports two things: which buffer it has loaded into its serializer, and whether the current attempt lost arbitration, hit an error or completed.

A buffer that is active but not loaded is withdrawn at once. A buffer that is already loaded cannot be withdrawn mid-frame. For such a buffer the request is latched as pending. It is resolved at the next safe point:
- If arbitration is lost or an error ends the attempt, the buffer takes the abort code.
- If the frame completes, the buffer takes the transmitted code.

In both cases the buffer's interrupt flag is raised, so software can tell from the final code which outcome occurred. With the feature disabled, every code write is stored as written and no pending state exists. This matches the legacy behaviour.

Top module: `tx_abort_ctrl`

## Requirements
- R1: After reset every buffer code reads 1000 (inactive), and all pending and interrupt flags read 0.
- R2: With abort_en_i low, a code write stores the written value, including 1001, and sets neither a pending flag nor an interrupt flag.
- R3: With abort_en_i high, writing 1001 to a buffer whose code is 1100 (queued for transmission) and that is not loaded sets its code to 1001 and raises its interrupt flag on the next clock edge.
- R4: With abort_en_i high, writing 1001 to the loaded buffer leaves its code unchanged and sets its pending flag.
- R5: When arbitration is lost or an error is reported for the loaded buffer while its abort is pending, the buffer code becomes 1001, its interrupt flag is raised and its pending flag clears.
- R6: When the loaded buffer completes transmission, its code becomes 1000, its interrupt flag is raised and its pending flag clears, whether or not an abort was pending.
- R7: Arbitration loss or error on the loaded buffer with no abort pending leaves its code at 1100 and raises no interrupt flag.
- R8: With abort_en_i high, any write to a buffer coded 1100, other than the abort code, is ignored. This holds whether or not the buffer is loaded. Writes to buffers with any other code are stored.
- R9: Each bit of irq_clr_i clears the matching interrupt flag. A flag being raised in the same cycle takes precedence over the clear.
- R10: While abort_en_i is low, every pending flag is cleared on the next edge.
- R11: Transmitter events act only while busy_i is high, and only on the buffer selected by busy_idx_i.
- R12: An abort write to the loaded buffer in the same cycle as arbitration loss aborts the buffer on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_en_i | input | 1 | Enables abort handling |
| wr_valid_i | input | 1 | Code write strobe |
| wr_idx_i | input | IDX_W | Buffer addressed by the write |
| wr_code_i | input | CODE_W | Code value written |
| busy_i | input | 1 | A buffer is loaded in the serializer |
| busy_idx_i | input | IDX_W | Index of the loaded buffer |
| arb_lost_i | input | 1 | Loaded frame lost arbitration |
| tx_err_i | input | 1 | Loaded frame ended in an error |
| tx_done_i | input | 1 | Loaded frame sent successfully |
| irq_clr_i | input | NUM_MB | Per-buffer interrupt flag clear |
| code_o | output | NUM_MB*CODE_W | Buffer codes, buffer i at bits [i*CODE_W +: CODE_W] |
| pend_o | output | NUM_MB | Abort pending per buffer |
| irq_o | output | NUM_MB | Interrupt flag per buffer |

## Verification
The bench builds the block with NUM_MB = 8 and CODE_W = 4. This gives a three-bit index and enough buffers to check that a transmitter event on one index leaves another active buffer untouched. The four-bit code width allows the exact 1000, 1001 and 1100 encodings to be checked. With eight interrupt-clear bits, a clear can be issued in the same cycle as a flag being raised, which is how the precedence rule is checked.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_SEND  = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_ABORT = 4'b1001;
endpackage

// File: rtl/tac_sel.sv
module tac_sel #(
  parameter int unsigned NUM_MB = 8,
  parameter int unsigned IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic             busy_i,
  input  logic [IDX_W-1:0] busy_idx_i,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic [NUM_MB-1:0] loaded_o,
  output logic [NUM_MB-1:0] wr_hit_o
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_dec
    assign loaded_o[i] = busy_i     && (busy_idx_i == IDX_W'(i));
    assign wr_hit_o[i] = wr_valid_i && (wr_idx_i   == IDX_W'(i));
  end
endmodule

// File: rtl/tac_slot.sv
module tac_slot
  import tac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_en_i,
  input  logic              loaded_i,
  input  logic              wr_hit_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              arb_lost_i,
  input  logic              tx_err_i,
  input  logic              tx_done_i,
  input  logic              irq_clr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic pend_q, pend_d, irq_q, irq_d;
  logic is_abort, eff_pend, fail_evt;

  assign is_abort = abort_en_i && wr_hit_i && (wr_code_i == CODE_ABORT);
  assign eff_pend = pend_q || (is_abort && loaded_i);
  assign fail_evt = loaded_i && (arb_lost_i || tx_err_i);

  always_comb begin
    code_d = code_q;
    pend_d = abort_en_i ? pend_q : 1'b0;
    irq_d  = irq_q & ~irq_clr_i;
    if (loaded_i && tx_done_i) begin
      code_d = CODE_IDLE;
      pend_d = 1'b0;
      irq_d  = 1'b1;
    end else if (fail_evt) begin
      if (abort_en_i && eff_pend) begin
        code_d = CODE_ABORT;
        pend_d = 1'b0;
        irq_d  = 1'b1;
      end
    end else if (wr_hit_i) begin
      if (!abort_en_i) begin
        code_d = wr_code_i;
      end else if (loaded_i) begin
        // loaded: hold the code, latch abort for the next safe point
        if (is_abort) pend_d = 1'b1;
      end else if (code_q == CODE_SEND) begin
        if (is_abort) begin
          code_d = CODE_ABORT;
          irq_d  = 1'b1;
        end
      end else begin
        code_d = wr_code_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_IDLE;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign code_o = code_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  assert_idle_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_abort && !loaded_i && code_q == CODE_SEND) |=> (code_q == CODE_ABORT && irq_q));

  assert_loaded_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_en_i && loaded_i && wr_hit_i && !arb_lost_i && !tx_err_i && !tx_done_i)
      |=> $stable(code_q));

  assert_pend_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_en_i && pend_q && fail_evt && !tx_done_i)
      |=> (code_q == CODE_ABORT && irq_q && !pend_q));

  assert_done_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_i && tx_done_i) |=> (code_q == CODE_IDLE && irq_q && !pend_q));

  assert_no_pend_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_en_i |=> !pend_q);

  assert_pend_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(loaded_i && abort_en_i));
endmodule

// File: rtl/tx_abort_ctrl.sv
module tx_abort_ctrl
  import tac_pkg::*;
#(
  parameter int unsigned NUM_MB = 8,
  parameter int unsigned IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     abort_en_i,
  input  logic                     wr_valid_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [CODE_W-1:0]        wr_code_i,
  input  logic                     busy_i,
  input  logic [IDX_W-1:0]         busy_idx_i,
  input  logic                     arb_lost_i,
  input  logic                     tx_err_i,
  input  logic                     tx_done_i,
  input  logic [NUM_MB-1:0]        irq_clr_i,
  output logic [NUM_MB*CODE_W-1:0] code_o,
  output logic [NUM_MB-1:0]        pend_o,
  output logic [NUM_MB-1:0]        irq_o
);
  logic [NUM_MB-1:0] loaded, wr_hit;

  tac_sel #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_sel (
    .busy_i     (busy_i),
    .busy_idx_i (busy_idx_i),
    .wr_valid_i (wr_valid_i),
    .wr_idx_i   (wr_idx_i),
    .loaded_o   (loaded),
    .wr_hit_o   (wr_hit)
  );

  for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
    tac_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .abort_en_i (abort_en_i),
      .loaded_i   (loaded[i]),
      .wr_hit_i   (wr_hit[i]),
      .wr_code_i  (wr_code_i),
      .arb_lost_i (arb_lost_i),
      .tx_err_i   (tx_err_i),
      .tx_done_i  (tx_done_i),
      .irq_clr_i  (irq_clr_i[i]),
      .code_o     (code_o[i*CODE_W +: CODE_W]),
      .pend_o     (pend_o[i]),
      .irq_o      (irq_o[i])
    );
  end

  // transmitter reports one outcome per attempt
  assert_evt_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> $onehot0({arb_lost_i, tx_err_i, tx_done_i}));

  // idle bus: no pending flag can appear
  assert_idle_no_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $countones(pend_o) <= $countones($past(pend_o)));
endmodule

// File: tb/tx_abort_ctrl_test.sv
`timescale 1ns/1ps
module tx_abort_ctrl_test;
  localparam int NUM_MB = 8;
  localparam int IDX_W  = 3;
  localparam int CW     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, wv, busy, arb, err, done;
  logic [IDX_W-1:0] widx, bidx;
  logic [CW-1:0] wcode;
  logic [NUM_MB-1:0] clr;
  logic [NUM_MB*CW-1:0] code;
  logic [NUM_MB-1:0] pend, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_abort_ctrl #(.NUM_MB(NUM_MB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .abort_en_i(en),
    .wr_valid_i(wv), .wr_idx_i(widx), .wr_code_i(wcode),
    .busy_i(busy), .busy_idx_i(bidx),
    .arb_lost_i(arb), .tx_err_i(err), .tx_done_i(done),
    .irq_clr_i(clr), .code_o(code), .pend_o(pend), .irq_o(irq)
  );

  typedef struct packed {
    logic       en;
    logic       wv;
    logic [2:0] widx;
    logic [3:0] wcode;
    logic       busy;
    logic [2:0] bidx;
    logic       arb;
    logic       err;
    logic       done;
    logic [7:0] clr;
    logic [2:0] chk;
    logic [3:0] ecode;
    logic       epend;
    logic       eirq;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 28;
  // en wv widx wcode busy bidx arb err done clr chk ecode epend eirq req
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0,1'b1,3'd2,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd2,4'hC,1'b0,1'b0,8'd2},  // R2
    '{1'b0,1'b1,3'd2,4'h9,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd2,4'h9,1'b0,1'b0,8'd2},  // R2
    '{1'b0,1'b1,3'd2,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd2,4'hC,1'b0,1'b0,8'd2},  // R2
    '{1'b1,1'b1,3'd2,4'h9,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd2,4'h9,1'b0,1'b1,8'd3},  // R3
    '{1'b1,1'b0,3'd0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,8'h04,3'd2,4'h9,1'b0,1'b0,8'd9},  // R9
    '{1'b1,1'b1,3'd3,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b0,1'b0,8'd8},  // R8
    '{1'b1,1'b1,3'd3,4'h8,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b0,1'b0,8'd8},  // R8
    '{1'b1,1'b1,3'd3,4'h9,1'b1,3'd3,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b1,1'b0,8'd4},  // R4
    '{1'b1,1'b1,3'd3,4'h4,1'b1,3'd3,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b1,1'b0,8'd8},  // R8
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd3,1'b1,1'b0,1'b0,8'h00,3'd3,4'h9,1'b0,1'b1,8'd5},  // R5
    '{1'b1,1'b1,3'd3,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h08,3'd3,4'hC,1'b0,1'b0,8'd9},  // R9
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd3,1'b1,1'b0,1'b0,8'h00,3'd3,4'hC,1'b0,1'b0,8'd7},  // R7
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd3,1'b0,1'b1,1'b0,8'h00,3'd3,4'hC,1'b0,1'b0,8'd7},  // R7
    '{1'b1,1'b1,3'd3,4'h9,1'b1,3'd3,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b1,1'b0,8'd4},  // R4
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd3,1'b0,1'b1,1'b0,8'h00,3'd3,4'h9,1'b0,1'b1,8'd5},  // R5
    '{1'b1,1'b1,3'd3,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h08,3'd3,4'hC,1'b0,1'b0,8'd9},  // R9
    '{1'b1,1'b1,3'd3,4'h9,1'b1,3'd3,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b1,1'b0,8'd4},  // R4
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd3,1'b0,1'b0,1'b1,8'h00,3'd3,4'h8,1'b0,1'b1,8'd6},  // R6
    '{1'b1,1'b1,3'd3,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h08,3'd3,4'hC,1'b0,1'b0,8'd9},  // R9
    '{1'b1,1'b0,3'd0,4'h0,1'b0,3'd3,1'b0,1'b0,1'b1,8'h00,3'd3,4'hC,1'b0,1'b0,8'd11}, // R11
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd3,1'b0,1'b0,1'b1,8'h00,3'd3,4'h8,1'b0,1'b1,8'd6},  // R6
    '{1'b1,1'b1,3'd3,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h08,3'd3,4'hC,1'b0,1'b0,8'd9},  // R9
    '{1'b1,1'b1,3'd3,4'h9,1'b1,3'd3,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b1,1'b0,8'd4},  // R4
    '{1'b0,1'b0,3'd0,4'h0,1'b1,3'd3,1'b0,1'b0,1'b0,8'h00,3'd3,4'hC,1'b0,1'b0,8'd10}, // R10
    '{1'b1,1'b1,3'd3,4'h9,1'b1,3'd3,1'b1,1'b0,1'b0,8'h00,3'd3,4'h9,1'b0,1'b1,8'd12}, // R12
    '{1'b1,1'b1,3'd5,4'hC,1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,3'd5,4'hC,1'b0,1'b0,8'd8},  // R8
    '{1'b1,1'b0,3'd0,4'h0,1'b1,3'd4,1'b0,1'b0,1'b1,8'h00,3'd5,4'hC,1'b0,1'b0,8'd11}, // R11
    '{1'b1,1'b1,3'd5,4'h9,1'b0,3'd0,1'b0,1'b0,1'b0,8'h20,3'd5,4'h9,1'b0,1'b1,8'd9}   // R9
  };

  task automatic idle_inputs();
    en = 0; wv = 0; widx = '0; wcode = '0; busy = 0; bidx = '0;
    arb = 0; err = 0; done = 0; clr = '0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic check_reset_state();
    for (int b = 0; b < NUM_MB; b++)
      check("R1 code", 64'(code[b*CW +: CW]), 64'(4'h8));
    check("R1 pend", 64'(pend), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      en = VEC[v].en; wv = VEC[v].wv; widx = VEC[v].widx; wcode = VEC[v].wcode;
      busy = VEC[v].busy; bidx = VEC[v].bidx; arb = VEC[v].arb; err = VEC[v].err;
      done = VEC[v].done; clr = VEC[v].clr;
      @(negedge clk);
      checks++;
      if (code[VEC[v].chk*CW +: CW] !== VEC[v].ecode || pend[VEC[v].chk] !== VEC[v].epend ||
          irq[VEC[v].chk] !== VEC[v].eirq) begin
        fails++;
        $display("FAIL R%0d vec %0d buf %0d: actual code=%h pend=%b irq=%b expected code=%h pend=%b irq=%b",
                 VEC[v].req, v, VEC[v].chk, code[VEC[v].chk*CW +: CW], pend[VEC[v].chk],
                 irq[VEC[v].chk], VEC[v].ecode, VEC[v].epend, VEC[v].eirq);
      end
    end
    idle_inputs();
    en = 1;
    @(negedge clk);
    // R11: buffer 3 untouched by the done event on index 4
    check("R11 buf3", 64'(code[3*CW +: CW]), 64'(4'h9));
    // R1: reset mid-run restores the initial state
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule